// File: doc/BRIEF.md
# Instruction Dispatch Controller

This block is the dispatch stage of a simplified out-of-order core. It takes decoded instructions one at a time from the head of an in-order queue and decides in the same cycle whether the head may leave. Each instruction carries a micro-op count, up to `NUM_DST` destination registers (each tagged with the register file it belongs to), up to `NUM_SRC` source registers, and a flag marking it as a zero-latency dependency-breaking operation, such as a register zeroing idiom.

The head is dispatched only when four conditions hold. No earlier oversized instruction may still be draining. Every register file must have enough free physical entries for the destinations it needs. The retire buffer must have room for all of the instruction's micro-ops. The scheduler must be ready. When dispatch happens, the block does all of the following in that cycle:
- marks which destinations take a physical register and which sources need read-after-write tracking;
- returns the retire-buffer slot it reserved;
- pushes the instruction to the scheduler.

One cycle later it reports a dispatched event with the per-file register usage. Retiring instructions produce a retired event one cycle later, listing the registers freed in each file.

When the head cannot leave, the block holds it in place, which keeps program order. For every blocked cycle it reports a 2-bit stall cause.

Top module: `dispatch_ctrl`

## Requirements
- R1: With no carry-over pending and every check passing, a valid head is dispatched in the cycle it is offered. `disp_valid` and `in_ready` go high together, and the register IDs, micro-op count and zero-latency flag pass through unchanged.
- R2: A head with more micro-ops than `DISPATCH_WIDTH` is dispatched and leaves a carry-over of (micro-ops − `DISPATCH_WIDTH`). The carry-over drops by `DISPATCH_WIDTH` (saturating at zero) in each later cycle, and nothing is dispatched while it is non-zero. An instruction of exactly `DISPATCH_WIDTH` micro-ops leaves no carry-over.
- R3: The head stalls with cause 1 (register file) if, for any file f, the number of its valid destinations tagged with file f is larger than that file's free count. The count excludes zero-latency heads. The file tag of destination d is `in_dst_file[d*FILE_W +: FILE_W]`, and the free count of file f is `rf_free[f*FREE_W +: FREE_W]`.
- R4: The head stalls with cause 2 (retire buffer) when `rob_free` is smaller than its micro-op count. It dispatches when `rob_free` equals the micro-op count.
- R5: The head stalls with cause 3 (scheduler) when `sched_ready` is low.
- R6: Stall causes follow a fixed priority: carry-over pending (cause 0) over register file (1) over retire buffer (2) over scheduler (3).
- R7: A zero-latency head allocates no physical register and tracks no source. `disp_dst_alloc`, `disp_src_track` and every `rf_alloc_cnt` field are zero, and the head passes the register-file check even when all free counts are zero.
- R8: `disp_rob_idx` is 0 for the first dispatch after reset. Each dispatch advances it by the micro-op count, modulo `ROB_DEPTH`.
- R9: One cycle after a dispatch, `evt_disp_valid` is high and `evt_disp_regs` holds the per-file allocation counts of that dispatch, using `CNT_W` bits per file with file f at bits `f*CNT_W`.
- R10: One cycle after `ret_valid`, `evt_ret_valid` is high and `evt_ret_regs` holds the per-file count of valid destinations of the retiring instruction. All counts are zero when `ret_zero_lat` is set.
- R11: After reset, with no input valid, no dispatch, stall or event output is active.
- R12: `stall_valid` is high exactly in the cycles where a valid head is not dispatched. While it is high, `in_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Queue head is valid |
| in_ready | output | 1 | Head consumed this cycle |
| in_uops | input | UOP_W | Micro-op count of the head |
| in_zero_lat | input | 1 | Head is a zero-latency dependency breaker |
| in_dst_valid | input | NUM_DST | Destination valid bits |
| in_dst_file | input | NUM_DST*FILE_W | Register file tag per destination |
| in_dst_reg | input | NUM_DST*REG_W | Destination register IDs |
| in_src_valid | input | NUM_SRC | Source valid bits |
| in_src_reg | input | NUM_SRC*REG_W | Source register IDs |
| rf_free | input | NUM_FILES*FREE_W | Free physical entries per file |
| rob_free | input | RBF_W | Free retire-buffer slots |
| sched_ready | input | 1 | Scheduler can accept an instruction |
| disp_valid | output | 1 | Dispatch this cycle, push to scheduler |
| disp_rob_idx | output | ROB_W | Reserved retire-buffer slot |
| disp_uops | output | UOP_W | Micro-op count sent downstream |
| disp_zero_lat | output | 1 | Zero-latency flag sent downstream |
| disp_dst_alloc | output | NUM_DST | Destinations that take a physical register |
| disp_dst_reg | output | NUM_DST*REG_W | Destination register IDs sent downstream |
| disp_src_track | output | NUM_SRC | Sources needing dependency tracking |
| disp_src_reg | output | NUM_SRC*REG_W | Source register IDs sent downstream |
| rf_alloc_cnt | output | NUM_FILES*CNT_W | Registers taken per file this cycle |
| stall_valid | output | 1 | Valid head blocked this cycle |
| stall_cause | output | 2 | 0 carry-over, 1 register file, 2 retire buffer, 3 scheduler |
| evt_disp_valid | output | 1 | Dispatched event |
| evt_disp_regs | output | NUM_FILES*CNT_W | Registers used per file in that dispatch |
| ret_valid | input | 1 | An instruction retires |
| ret_zero_lat | input | 1 | Retiring instruction was zero-latency |
| ret_dst_valid | input | NUM_DST | Retiring destination valid bits |
| ret_dst_file | input | NUM_DST*FILE_W | Retiring destination file tags |
| evt_ret_valid | output | 1 | Retired event |
| evt_ret_regs | output | NUM_FILES*CNT_W | Registers freed per file |

## Verification
A carry-over counter that is wrong shows up at once as extra or missing blocked cycles after an oversized dispatch. It appears as `stall_cause` 0 or as a `disp_valid` in the wrong cycle, within `ceil(uops/DISPATCH_WIDTH)` cycles. A corrupted retire-slot pointer shows up on the next dispatch's `disp_rob_idx`, so the bench follows the index across a wrap of the buffer. Errors in the per-file counts or in the check priority show up in the same cycle on `rf_alloc_cnt` and `stall_cause`, and one cycle later on the event counts. The bench sets up conflicting failures so that each priority level is observed.

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl #(
  parameter int DISPATCH_WIDTH = 4,
  parameter int UOP_W          = 4,
  parameter int NUM_DST        = 2,
  parameter int NUM_SRC        = 2,
  parameter int REG_W          = 6,
  parameter int NUM_FILES      = 2,
  parameter int FREE_W         = 6,
  parameter int ROB_DEPTH      = 32,
  localparam int FILE_W        = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1,
  localparam int CNT_W         = $clog2(NUM_DST + 1),
  localparam int ROB_W         = $clog2(ROB_DEPTH),
  localparam int RBF_W         = $clog2(ROB_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [UOP_W-1:0]           in_uops,
  input  logic                       in_zero_lat,
  input  logic [NUM_DST-1:0]         in_dst_valid,
  input  logic [NUM_DST*FILE_W-1:0]  in_dst_file,
  input  logic [NUM_DST*REG_W-1:0]   in_dst_reg,
  input  logic [NUM_SRC-1:0]         in_src_valid,
  input  logic [NUM_SRC*REG_W-1:0]   in_src_reg,
  input  logic [NUM_FILES*FREE_W-1:0] rf_free,
  input  logic [RBF_W-1:0]           rob_free,
  input  logic                       sched_ready,
  output logic                       disp_valid,
  output logic [ROB_W-1:0]           disp_rob_idx,
  output logic [UOP_W-1:0]           disp_uops,
  output logic                       disp_zero_lat,
  output logic [NUM_DST-1:0]         disp_dst_alloc,
  output logic [NUM_DST*REG_W-1:0]   disp_dst_reg,
  output logic [NUM_SRC-1:0]         disp_src_track,
  output logic [NUM_SRC*REG_W-1:0]   disp_src_reg,
  output logic [NUM_FILES*CNT_W-1:0] rf_alloc_cnt,
  output logic                       stall_valid,
  output logic [1:0]                 stall_cause,
  output logic                       evt_disp_valid,
  output logic [NUM_FILES*CNT_W-1:0] evt_disp_regs,
  input  logic                       ret_valid,
  input  logic                       ret_zero_lat,
  input  logic [NUM_DST-1:0]         ret_dst_valid,
  input  logic [NUM_DST*FILE_W-1:0]  ret_dst_file,
  output logic                       evt_ret_valid,
  output logic [NUM_FILES*CNT_W-1:0] evt_ret_regs
);

  localparam logic [1:0] C_CARRY = 2'd0;
  localparam logic [1:0] C_RF    = 2'd1;
  localparam logic [1:0] C_ROB   = 2'd2;
  localparam logic [1:0] C_SCHED = 2'd3;

  logic [UOP_W-1:0]           carry_q;
  logic [ROB_W-1:0]           tail_q;
  logic [NUM_FILES*CNT_W-1:0] need, freed;
  logic                       rf_ok, rob_ok, busy, fire;
  logic                       wide;

  always_comb begin
    need  = '0;
    freed = '0;
    for (int f = 0; f < NUM_FILES; f++) begin
      for (int d = 0; d < NUM_DST; d++) begin
        if (in_dst_valid[d] && !in_zero_lat &&
            in_dst_file[d*FILE_W +: FILE_W] == FILE_W'(f))
          need[f*CNT_W +: CNT_W] = need[f*CNT_W +: CNT_W] + CNT_W'(1);
        if (ret_dst_valid[d] && !ret_zero_lat &&
            ret_dst_file[d*FILE_W +: FILE_W] == FILE_W'(f))
          freed[f*CNT_W +: CNT_W] = freed[f*CNT_W +: CNT_W] + CNT_W'(1);
      end
    end
  end

  always_comb begin
    rf_ok = 1'b1;
    for (int f = 0; f < NUM_FILES; f++)
      if (FREE_W'(need[f*CNT_W +: CNT_W]) > rf_free[f*FREE_W +: FREE_W])
        rf_ok = 1'b0;
  end

  assign busy   = (carry_q != '0);
  assign rob_ok = int'(rob_free) >= int'(in_uops);
  assign fire   = in_valid && !busy && rf_ok && rob_ok && sched_ready;
  assign wide   = int'(in_uops) > DISPATCH_WIDTH;

  assign in_ready       = fire;
  assign disp_valid     = fire;
  assign disp_rob_idx   = tail_q;
  assign disp_uops      = in_uops;
  assign disp_zero_lat  = in_zero_lat;
  assign disp_dst_alloc = in_zero_lat ? '0 : in_dst_valid;
  assign disp_src_track = in_zero_lat ? '0 : in_src_valid;
  assign disp_dst_reg   = in_dst_reg;
  assign disp_src_reg   = in_src_reg;
  assign rf_alloc_cnt   = fire ? need : '0;

  assign stall_valid = in_valid && !fire;
  assign stall_cause = busy    ? C_CARRY :
                       !rf_ok  ? C_RF    :
                       !rob_ok ? C_ROB   : C_SCHED;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= '0;
    end else if (busy) begin
      carry_q <= (int'(carry_q) > DISPATCH_WIDTH) ?
                 carry_q - UOP_W'(DISPATCH_WIDTH) : '0;
    end else if (fire && wide) begin
      carry_q <= in_uops - UOP_W'(DISPATCH_WIDTH);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (fire) begin
      if (int'(tail_q) + int'(in_uops) >= ROB_DEPTH)
        tail_q <= ROB_W'(int'(tail_q) + int'(in_uops) - ROB_DEPTH);
      else
        tail_q <= ROB_W'(int'(tail_q) + int'(in_uops));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_disp_valid <= 1'b0;
      evt_disp_regs  <= '0;
      evt_ret_valid  <= 1'b0;
      evt_ret_regs   <= '0;
    end else begin
      evt_disp_valid <= fire;
      evt_disp_regs  <= fire ? need : '0;
      evt_ret_valid  <= ret_valid;
      evt_ret_regs   <= ret_valid ? freed : '0;
    end
  end

endmodule

module dispatch_ctrl_chk #(
  parameter int DISPATCH_WIDTH = 4,
  parameter int UOP_W          = 4,
  parameter int NUM_DST        = 2,
  parameter int NUM_SRC        = 2,
  parameter int NUM_FILES      = 2,
  parameter int FREE_W         = 6,
  parameter int CNT_W          = 2,
  parameter int RBF_W          = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        disp_valid,
  input logic [UOP_W-1:0]            disp_uops,
  input logic                        disp_zero_lat,
  input logic [NUM_DST-1:0]          disp_dst_alloc,
  input logic [NUM_SRC-1:0]          disp_src_track,
  input logic [NUM_FILES*CNT_W-1:0]  rf_alloc_cnt,
  input logic [NUM_FILES*FREE_W-1:0] rf_free,
  input logic [RBF_W-1:0]            rob_free,
  input logic                        sched_ready,
  input logic                        stall_valid,
  input logic                        evt_disp_valid,
  input logic                        ret_valid,
  input logic                        evt_ret_valid
);

  a_r2_carry_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && int'(disp_uops) > DISPATCH_WIDTH) |=> !disp_valid);

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_rf
    a_r3_rf_fits: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> FREE_W'(rf_alloc_cnt[f*CNT_W +: CNT_W]) <= rf_free[f*FREE_W +: FREE_W]);
  end

  a_r4_rob_fits: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> int'(rob_free) >= int'(disp_uops));

  a_r5_sched_ready: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> sched_ready);

  a_r7_zero_lat_free: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_zero_lat) |-> (disp_dst_alloc == '0 && disp_src_track == '0 && rf_alloc_cnt == '0));

  a_r9_disp_event: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> evt_disp_valid);

  a_r10_ret_event: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> evt_ret_valid);

  a_r12_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    stall_valid |-> (in_valid && !disp_valid));

endmodule

bind dispatch_ctrl dispatch_ctrl_chk #(
  .DISPATCH_WIDTH(DISPATCH_WIDTH), .UOP_W(UOP_W), .NUM_DST(NUM_DST),
  .NUM_SRC(NUM_SRC), .NUM_FILES(NUM_FILES), .FREE_W(FREE_W),
  .CNT_W(CNT_W), .RBF_W(RBF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .disp_valid(disp_valid),
  .disp_uops(disp_uops), .disp_zero_lat(disp_zero_lat),
  .disp_dst_alloc(disp_dst_alloc), .disp_src_track(disp_src_track),
  .rf_alloc_cnt(rf_alloc_cnt), .rf_free(rf_free), .rob_free(rob_free),
  .sched_ready(sched_ready), .stall_valid(stall_valid),
  .evt_disp_valid(evt_disp_valid), .ret_valid(ret_valid),
  .evt_ret_valid(evt_ret_valid)
);

// File: tb/test_dispatch_ctrl.sv
module test_dispatch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 0, in_ready, in_zero_lat = 0;
  logic [3:0]  in_uops = 0;
  logic [1:0]  in_dst_valid = 0, in_dst_file = 0, in_src_valid = 0;
  logic [11:0] in_dst_reg = 0, in_src_reg = 0;
  logic [11:0] rf_free = {6'd8, 6'd8};
  logic [5:0]  rob_free = 6'd32;
  logic        sched_ready = 1;
  logic        disp_valid, disp_zero_lat, stall_valid, evt_disp_valid, evt_ret_valid;
  logic [4:0]  disp_rob_idx;
  logic [3:0]  disp_uops, rf_alloc_cnt, evt_disp_regs, evt_ret_regs;
  logic [1:0]  disp_dst_alloc, disp_src_track, stall_cause;
  logic [11:0] disp_dst_reg, disp_src_reg;
  logic        ret_valid = 0, ret_zero_lat = 0;
  logic [1:0]  ret_dst_valid = 0, ret_dst_file = 0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dispatch_ctrl i_dispatch_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_uops(in_uops), .in_zero_lat(in_zero_lat), .in_dst_valid(in_dst_valid),
    .in_dst_file(in_dst_file), .in_dst_reg(in_dst_reg), .in_src_valid(in_src_valid),
    .in_src_reg(in_src_reg), .rf_free(rf_free), .rob_free(rob_free),
    .sched_ready(sched_ready), .disp_valid(disp_valid), .disp_rob_idx(disp_rob_idx),
    .disp_uops(disp_uops), .disp_zero_lat(disp_zero_lat), .disp_dst_alloc(disp_dst_alloc),
    .disp_dst_reg(disp_dst_reg), .disp_src_track(disp_src_track), .disp_src_reg(disp_src_reg),
    .rf_alloc_cnt(rf_alloc_cnt), .stall_valid(stall_valid), .stall_cause(stall_cause),
    .evt_disp_valid(evt_disp_valid), .evt_disp_regs(evt_disp_regs),
    .ret_valid(ret_valid), .ret_zero_lat(ret_zero_lat), .ret_dst_valid(ret_dst_valid),
    .ret_dst_file(ret_dst_file), .evt_ret_valid(evt_ret_valid), .evt_ret_regs(evt_ret_regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic offer(input int uops, input logic zl, input logic [1:0] dv,
                       input logic [1:0] df, input logic [1:0] sv);
    in_valid = 1; in_uops = 4'(uops); in_zero_lat = zl;
    in_dst_valid = dv; in_dst_file = df; in_src_valid = sv;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R11 disp_valid", disp_valid, 0);
    chk("R11 stall_valid", stall_valid, 0);
    chk("R11 evt_disp_valid", evt_disp_valid, 0);
    chk("R11 evt_ret_valid", evt_ret_valid, 0);
  endtask

  task automatic t_simple();
    @(negedge clk);
    offer(2, 0, 2'b11, 2'b10, 2'b11);
    in_dst_reg = 12'h5A3; in_src_reg = 12'h9C1;
    #1;
    chk("R1 disp_valid", disp_valid, 1);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 dst_reg", disp_dst_reg, 12'h5A3);
    chk("R1 src_reg", disp_src_reg, 12'h9C1);
    chk("R1 uops", disp_uops, 2);
    chk("R8 first idx", disp_rob_idx, 0);
    chk("R3 alloc cnt", rf_alloc_cnt, 4'b0101);
    chk("R7 normal alloc", disp_dst_alloc, 2'b11);
    chk("R7 normal track", disp_src_track, 2'b11);
    @(posedge clk); #1;
    in_valid = 0;
    chk("R9 evt valid", evt_disp_valid, 1);
    chk("R9 evt regs", evt_disp_regs, 4'b0101);
  endtask

  task automatic t_big();
    @(negedge clk);
    offer(9, 0, 2'b01, 2'b00, 2'b00);
    #1;
    chk("R2 big dispatched", disp_valid, 1);
    chk("R8 idx 2", disp_rob_idx, 2);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      offer(1, 0, 2'b00, 2'b00, 2'b00);
      #1;
      chk("R2 carry blocks", disp_valid, 0);
      chk("R12 stall valid", stall_valid, 1);
      chk("R12 in_ready low", in_ready, 0);
      chk("R6 cause carry", stall_cause, 0);
    end
    @(negedge clk); #1;
    chk("R2 resumes", disp_valid, 1);
    chk("R8 idx 11", disp_rob_idx, 11);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic t_checks();
    @(negedge clk);
    offer(3, 0, 2'b11, 2'b00, 2'b00);
    rf_free = {6'd8, 6'd1}; rob_free = 0; sched_ready = 0;
    #1;
    chk("R3 rf stall", disp_valid, 0);
    chk("R6 cause rf over rob", stall_cause, 1);
    @(negedge clk);
    rf_free = {6'd0, 6'd2};
    #1;
    chk("R4 rob stall", disp_valid, 0);
    chk("R6 cause rob over sched", stall_cause, 2);
    @(negedge clk);
    rob_free = 2;
    #1;
    chk("R4 rob one short", stall_cause, 2);
    @(negedge clk);
    rob_free = 3;
    #1;
    chk("R5 sched stall", disp_valid, 0);
    chk("R5 cause sched", stall_cause, 3);
    @(negedge clk);
    sched_ready = 1;
    #1;
    chk("R4 exact fit dispatches", disp_valid, 1);
    chk("R12 no stall on dispatch", stall_valid, 0);
    chk("R8 idx 12", disp_rob_idx, 12);
    @(posedge clk); #1;
    in_valid = 0; rob_free = 32;
  endtask

  task automatic t_zero_lat();
    @(negedge clk);
    offer(1, 1, 2'b11, 2'b00, 2'b11);
    rf_free = '0;
    #1;
    chk("R7 zl dispatches", disp_valid, 1);
    chk("R7 zl no alloc", disp_dst_alloc, 0);
    chk("R7 zl no track", disp_src_track, 0);
    chk("R7 zl cnt", rf_alloc_cnt, 0);
    chk("R8 idx 15", disp_rob_idx, 15);
    @(posedge clk); #1;
    in_valid = 0; rf_free = {6'd8, 6'd8};
    chk("R9 zl evt regs", evt_disp_regs, 0);
  endtask

  task automatic t_wrap();
    int exp_idx [3] = '{16, 24, 0};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      offer(8, 0, 2'b00, 2'b00, 2'b00);
      #1;
      chk("R8 wrap idx", disp_rob_idx, 32'(exp_idx[k]));
      @(posedge clk); #1;
      in_valid = 0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_carry_priority();
    @(negedge clk);
    offer(5, 0, 2'b00, 2'b00, 2'b00);
    #1;
    chk("R2 uops5 dispatched", disp_valid, 1);
    chk("R8 idx 8", disp_rob_idx, 8);
    @(negedge clk);
    offer(1, 0, 2'b01, 2'b00, 2'b00);
    rf_free = '0;
    #1;
    chk("R6 carry over rf", stall_cause, 0);
    @(negedge clk); #1;
    chk("R2 carry drained", stall_cause, 1);
    in_valid = 0; rf_free = {6'd8, 6'd8};
  endtask

  task automatic t_exact_width();
    @(negedge clk);
    offer(4, 0, 2'b00, 2'b00, 2'b00);
    #1;
    chk("R2 width dispatched", disp_valid, 1);
    chk("R8 idx 13", disp_rob_idx, 13);
    @(negedge clk);
    offer(1, 0, 2'b00, 2'b00, 2'b00);
    #1;
    chk("R2 no carry at width", disp_valid, 1);
    chk("R8 idx 17", disp_rob_idx, 17);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic t_retire();
    @(negedge clk);
    ret_valid = 1; ret_zero_lat = 0; ret_dst_valid = 2'b11; ret_dst_file = 2'b10;
    @(posedge clk); #1;
    chk("R10 ret valid", evt_ret_valid, 1);
    chk("R10 ret regs", evt_ret_regs, 4'b0101);
    @(negedge clk);
    ret_dst_file = 2'b11;
    @(posedge clk); #1;
    chk("R10 ret same file", evt_ret_regs, 4'b1000);
    @(negedge clk);
    ret_zero_lat = 1;
    @(posedge clk); #1;
    chk("R10 zl ret valid", evt_ret_valid, 1);
    chk("R10 zl ret regs", evt_ret_regs, 0);
    @(negedge clk);
    ret_valid = 0;
    @(posedge clk); #1;
    chk("R10 ret idle", evt_ret_valid, 0);
  endtask

  initial begin
    #1_600_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_simple();
    t_big();
    t_checks();
    t_zero_lat();
    t_wrap();
    t_carry_priority();
    t_exact_width();
    t_retire();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule